// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Trigger-Level Interrupts

This block holds the two byte queues of a UART. One queue is the transmit side, which the host fills and the serializer drains. The other is the receive side, which the deserializer fills and the host drains. A control register, written over a simple address/data write strobe, does four things:

- it switches both queues between full-depth operation and single-byte holding mode;
- it flushes either queue with a bit that clears itself;
- it picks a coded receive trigger level;
- it picks a coded transmit trigger level.

Two level-sensitive interrupts are derived every cycle from the fill counts. A receive-ready interrupt fires once enough bytes have arrived. A transmit-empty interrupt fires once the transmit queue has fallen below its threshold.

Four further 8-bit registers can override the coded levels: a receive level, a transmit level, and two flow thresholds. As soon as any of the four is nonzero, the receive and transmit thresholds are taken directly from the receive-level and transmit-level registers. Each queue shows its oldest byte on its read-data port, which lets a pop consume that byte in the same cycle.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, both counts are 0, both overrun flags are 0, the receive interrupt is 0, the transmit interrupt is 1, and the queues are in holding mode.
- R2: With control bit 0 set, each queue stores up to DEPTH bytes and returns them in push order. The read-data port shows the oldest byte while the queue is not empty.
- R3: With control bit 0 clear, each queue holds at most one byte. The receive interrupt is then 1 exactly when a byte is held, and the transmit interrupt is 1 exactly when the queue is empty.
- R4: A control write (address 0) with bit 1 set empties the receive queue and clears its overrun flag, and leaves the transmit queue untouched. The bit is not retained, so later pushes are counted normally.
- R5: A control write with bit 2 set empties the transmit queue and clears its overrun flag, and leaves the receive queue untouched. The bit is not retained.
- R6: A control write that changes bit 0 empties both queues and clears both overrun flags.
- R7: With no override active, control bits 7:6 give the receive threshold: 00→8, 01→16, 10→24, 11→28. In full-depth mode the receive interrupt is 1 when the receive count is at least the threshold.
- R8: With no override active, control bits 5:4 give the transmit threshold with the same coding. In full-depth mode the transmit interrupt is 1 when the transmit count is below the threshold.
- R9: Writes to address 1 (receive level), 2 (transmit level), 3 (flow low) and 4 (flow high) each set an 8-bit register. If any of the four is nonzero, the thresholds are taken from addresses 1 and 2 and the coded fields are ignored. The receive interrupt is never 1 while the receive queue is empty.
- R10: A push into a full queue without a simultaneous pop is dropped, leaves the count unchanged, and sets that queue's overrun flag. The flag stays set until the queue is flushed.
- R11: A pop from an empty queue leaves the count at 0, and the read-data port shows 0 while the queue is empty.
- R12: A push and a pop in the same cycle on a full queue are both accepted. The count stays the same and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1–4 level registers) |
| reg_wdata | input | 8 | Register write data |
| tx_push | input | 1 | Host writes a byte into the transmit queue |
| tx_wdata | input | DW | Transmit byte to push |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| tx_rdata | output | DW | Oldest transmit byte, 0 when empty |
| rx_push | input | 1 | Deserializer delivers a received byte |
| rx_wdata | input | DW | Received byte to push |
| rx_pop | input | 1 | Host takes the oldest received byte |
| rx_rdata | output | DW | Oldest received byte, 0 when empty |
| tx_count | output | CW | Transmit fill count |
| rx_count | output | CW | Receive fill count |
| tx_overrun | output | 1 | Sticky: a transmit push was dropped |
| rx_overrun | output | 1 | Sticky: a receive push was dropped |
| rx_ready_irq | output | 1 | Receive-ready interrupt |
| tx_empty_irq | output | 1 | Transmit-empty interrupt |

## Verification
The bench builds the block with its defaults, DEPTH = 32 and DW = 8. With these values all four coded thresholds, the largest being 28, lie below the queue capacity, so every threshold can be probed one byte below and exactly at its boundary. The same values make it cheap enough to fill a queue completely, which brings the overflow drop, the full-queue push-with-pop case and the complete ordered drain within reach.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          tx_overrun,
  output logic          rx_overrun,
  output logic          rx_ready_irq,
  output logic          tx_empty_irq
);

  logic       fifo_en;
  logic [1:0] rx_code, tx_code;
  logic [7:0] lvl_rx, lvl_tx, flow_lo, flow_hi;

  wire ctl_wr = reg_wr && (reg_addr == 3'd0);
  wire en_chg = ctl_wr && (reg_wdata[0] != fifo_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fifo_en <= 1'b0;
      rx_code <= '0;
      tx_code <= '0;
      lvl_rx  <= '0;
      lvl_tx  <= '0;
      flow_lo <= '0;
      flow_hi <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: begin
          fifo_en <= reg_wdata[0];
          tx_code <= reg_wdata[5:4];
          rx_code <= reg_wdata[7:6];
        end
        3'd1: lvl_rx  <= reg_wdata;
        3'd2: lvl_tx  <= reg_wdata;
        3'd3: flow_lo <= reg_wdata;
        3'd4: flow_hi <= reg_wdata;
        default: ;
      endcase
    end

  // index 0 = transmit, 1 = receive
  logic [1:0]    push_v, pop_v, clr_v, ovr_v;
  logic [DW-1:0] wd_v [2];
  logic [DW-1:0] rd_v [2];
  logic [CW-1:0] cnt_v [2];

  assign push_v = {rx_push, tx_push};
  assign pop_v  = {rx_pop, tx_pop};
  assign wd_v[0] = tx_wdata;
  assign wd_v[1] = rx_wdata;
  assign clr_v[0] = ctl_wr && (reg_wdata[2] || en_chg);
  assign clr_v[1] = ctl_wr && (reg_wdata[1] || en_chg);

  wire [CW-1:0] cap = fifo_en ? CW'(DEPTH) : CW'(1);

  for (genvar g = 0; g < 2; g++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          ovr;

    wire do_pop  = pop_v[g] && (cnt != '0);
    wire do_push = push_v[g] && ((cnt < cap) || do_pop);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rp <= '0; wp <= '0; cnt <= '0; ovr <= 1'b0;
      end else if (clr_v[g]) begin
        rp <= '0; wp <= '0; cnt <= '0; ovr <= 1'b0;
      end else begin
        if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
        if (push_v[g] && !do_push) ovr <= 1'b1;
      end

    always_ff @(posedge clk)
      if (do_push && !clr_v[g]) mem[wp] <= wd_v[g];

    assign cnt_v[g] = cnt;
    assign ovr_v[g] = ovr;
    assign rd_v[g]  = (cnt != '0) ? mem[rp] : '0;

    a_r3_holding_cap: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> cnt <= CW'(1));
    a_r2_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
  end

  assign tx_count   = cnt_v[0];
  assign rx_count   = cnt_v[1];
  assign tx_rdata   = rd_v[0];
  assign rx_rdata   = rd_v[1];
  assign tx_overrun = ovr_v[0];
  assign rx_overrun = ovr_v[1];

  function automatic logic [7:0] code_lvl(input logic [1:0] c);
    case (c)
      2'd0: return 8'd8;
      2'd1: return 8'd16;
      2'd2: return 8'd24;
      default: return 8'd28;
    endcase
  endfunction

  wire       override = |{lvl_rx, lvl_tx, flow_lo, flow_hi};
  wire [7:0] rx_trig  = override ? lvl_rx : code_lvl(rx_code);
  wire [7:0] tx_trig  = override ? lvl_tx : code_lvl(tx_code);

  assign rx_ready_irq = (rx_count != '0) &&
                        (!fifo_en || (32'(rx_count) >= 32'(rx_trig)));
  assign tx_empty_irq = fifo_en ? (32'(tx_count) < 32'(tx_trig))
                                : (tx_count == '0);

  a_r9_rx_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready_irq |-> rx_count != '0);
  a_r4_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[1]) |=> (rx_count == '0 && !rx_overrun));
  a_r5_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[2]) |=> (tx_count == '0 && !tx_overrun));
  a_r10_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && rx_push && !rx_pop && fifo_en && rx_count == CW'(DEPTH))
      |=> (rx_overrun && $stable(rx_count)));
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && rx_pop && !rx_push && rx_count == '0) |=> rx_count == '0);
  a_r11_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count == '0 |-> tx_rdata == '0);

endmodule

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;
  localparam int DEPTH = 32;
  localparam int DW = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [DW-1:0] tx_wdata = 0, rx_wdata = 0, tx_rdata, rx_rdata;
  logic [CW-1:0] tx_count, rx_count;
  logic tx_overrun, rx_overrun, rx_ready_irq, tx_empty_irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  uart_fifo_ctl #(.DEPTH(DEPTH), .DW(DW)) i_uart_fifo_ctl (.*);

  // {rx code, tx code, bytes, expected rx irq, expected tx irq}
  localparam logic [11:0] VEC [10] = '{
    {2'd0, 2'd0, 6'd7,  1'b0, 1'b1}, {2'd0, 2'd0, 6'd8,  1'b1, 1'b0},
    {2'd1, 2'd1, 6'd15, 1'b0, 1'b1}, {2'd1, 2'd1, 6'd16, 1'b1, 1'b0},
    {2'd2, 2'd2, 6'd23, 1'b0, 1'b1}, {2'd2, 2'd2, 6'd24, 1'b1, 1'b0},
    {2'd3, 2'd3, 6'd27, 1'b0, 1'b1}, {2'd3, 2'd3, 6'd28, 1'b1, 1'b0},
    {2'd0, 2'd3, 6'd20, 1'b1, 1'b1}, {2'd3, 2'd0, 6'd20, 1'b0, 1'b0}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic push_rx(logic [7:0] d);
    @(negedge clk); rx_push = 1; rx_wdata = d;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic push_tx(logic [7:0] d);
    @(negedge clk); tx_push = 1; tx_wdata = d;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rx_count", rx_count, 0);
    check("R1 tx_count", tx_count, 0);
    check("R1 rx_irq", rx_ready_irq, 0);
    check("R1 tx_irq", tx_empty_irq, 1);
    check("R1 overruns", {tx_overrun, rx_overrun}, 0);

    // coded trigger table (R7, R8)
    for (int v = 0; v < 10; v++) begin
      wr(3'd0, {VEC[v][11:10], VEC[v][9:8], 4'b0111});
      @(negedge clk); tx_push = 1; rx_push = 1;
      for (int k = 0; k < int'(VEC[v][7:2]); k++) begin
        tx_wdata = 8'(k); rx_wdata = 8'(k);
        @(negedge clk);
      end
      tx_push = 0; rx_push = 0;
      check($sformatf("R7 rx_irq vec %0d", v), rx_ready_irq, int'(VEC[v][1]));
      check($sformatf("R8 tx_irq vec %0d", v), tx_empty_irq, int'(VEC[v][0]));
    end

    // R6: leaving full-depth mode flushes both queues
    wr(3'd0, 8'h00);
    check("R6 rx flushed", rx_count, 0);
    check("R6 tx flushed", tx_count, 0);

    // R3 holding mode, R10 overrun, R11 empty pop
    push_rx(8'hA5);
    check("R3 rx count", rx_count, 1);
    check("R3 rx irq one byte", rx_ready_irq, 1);
    push_rx(8'h5A);
    check("R10 rx dropped", rx_count, 1);
    check("R10 rx overrun", rx_overrun, 1);
    check("R3 rx head", rx_rdata, 8'hA5);
    pop_rx();
    check("R11 rx data empty", rx_rdata, 0);
    pop_rx();
    check("R11 rx pop empty", rx_count, 0);
    check("R10 overrun sticky", rx_overrun, 1);
    check("R3 tx irq empty", tx_empty_irq, 1);
    push_tx(8'h33);
    check("R3 tx irq held", tx_empty_irq, 0);

    // R6: entering full-depth mode flushes both
    wr(3'd0, 8'h01);
    check("R6 tx flushed on enable", tx_count, 0);
    check("R6 overrun cleared", rx_overrun, 0);

    // R2 ordering and depth, R10 overflow
    for (int k = 0; k < DEPTH; k++) push_rx(8'(8'h40 + k));
    check("R2 rx full", rx_count, DEPTH);
    push_rx(8'hEE);
    check("R10 full drop", rx_count, DEPTH);
    check("R10 full overrun", rx_overrun, 1);
    for (int k = 0; k < DEPTH; k++) begin
      check("R2 order", rx_rdata, 8'h40 + k);
      pop_rx();
    end
    check("R11 drained", rx_count, 0);
    check("R11 drained data", rx_rdata, 0);

    // R12 push with pop on full queue
    for (int k = 0; k < DEPTH; k++) push_tx(8'(k));
    @(negedge clk); tx_push = 1; tx_pop = 1; tx_wdata = 8'h99;
    @(negedge clk); tx_push = 0; tx_pop = 0;
    check("R12 count kept", tx_count, DEPTH);
    check("R12 no overrun", tx_overrun, 0);
    check("R12 head advanced", tx_rdata, 1);

    // R4 receive flush
    push_rx(8'h11); push_rx(8'h22);
    wr(3'd0, 8'h03);
    check("R4 rx flushed", rx_count, 0);
    check("R4 rx overrun cleared", rx_overrun, 0);
    check("R4 tx untouched", tx_count, DEPTH);
    push_rx(8'h77);
    check("R4 self clear", rx_count, 1);

    // R5 transmit flush
    wr(3'd0, 8'h05);
    check("R5 tx flushed", tx_count, 0);
    check("R5 rx untouched", rx_count, 1);

    // R9 override levels
    wr(3'd4, 8'h05);
    check("R9 rx lvl0 nonempty", rx_ready_irq, 1);
    check("R9 tx lvl0", tx_empty_irq, 0);
    wr(3'd1, 8'd3); wr(3'd2, 8'd2);
    check("R9 rx below level", rx_ready_irq, 0);
    push_rx(8'h01); push_rx(8'h02);
    check("R9 rx at level", rx_ready_irq, 1);
    push_tx(8'h01);
    check("R9 tx below level", tx_empty_irq, 1);
    push_tx(8'h02);
    check("R9 tx at level", tx_empty_irq, 0);
    wr(3'd4, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    check("R9 back to coded rx", rx_ready_irq, 0);
    check("R9 back to coded tx", tx_empty_irq, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule